// File: doc/BRIEF.md
# Programmable receiver bit-rate generator

This block turns a fixed 10 MHz reference clock into a bit-rate strobe for a serial receiver. It emits a pulse one clock wide once per bit period, and the receiver's sampling logic uses that pulse. The divide chain has three stages in series. The first is a fixed divide-by-29 prescaler. The second is a divide-by-8 stage, switched in or out by a single select bit. The last is a divide-by-(R+1) counter, where R is a 7-bit value.

Both R and the select bit come from one 16-bit command word on a parallel write port. The block accepts a word only when its upper byte is the rate opcode C8h. Every other word is dropped, and the running divider is left alone.

When the block accepts a command it restarts the whole chain, so the new rate begins with a full bit period. A synchronous reset loads the power-on word C813h, which gives a period of 580 reference cycles.

Top module: `rate_tick_gen`

## Requirements
- R1: When `wr_en` is high and `wr_data[15:8]` equals C8h, the block stores `wr_data[6:0]` as the divider value R and `wr_data[7]` as the prescale select `cs`.
- R2: A write whose upper byte is not C8h changes neither the stored rate nor the tick phase. Nor does a cycle with `wr_en` low, whatever `wr_data` holds.
- R3: With `cs`=0, ticks repeat every 29·(R+1) reference cycles.
- R4: With `cs`=1, ticks repeat every 232·(R+1) reference cycles.
- R5: `tick` is high for exactly one reference cycle in each bit period.
- R6: A synchronous active-high `rst` loads the word C813h, which means R=19 and `cs`=0. `tick` stays low while reset is asserted. The first tick comes in the 580th cycle after the last reset edge.
- R7: An accepted rate command restarts all counters. The first tick under the new setting comes in the 29·(1+7·cs)·(R+1)-th cycle after the write edge, even if the write lands in the middle of a period.
- R8: The extreme settings R=0 and R=127 work with either value of `cs`. So do the standard-rate settings R=2,`cs`=0 (about 115.2 kbps) and R=71,`cs`=1 (about 600 bps).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset to the power-on rate |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 16 | Command word: opcode in [15:8], `cs` in [7], R in [6:0] |
| tick | output | 1 | One-cycle bit-rate strobe |

## Verification
The hardest cases to reach from the ports are two writes that land partway through a long period. One is a rejected write, which must leave the tick phase untouched. The other is an accepted write, which must throw the old phase away. The scoreboard driver keeps the already-scheduled tick times when it issues a rejected word. It issues that word a few hundred cycles into a period, so a restart caused by mistake would shift the next tick and show up as a mismatch. For an accepted write, the driver flushes the queue and schedules the ticks again from the write edge. Runs at R=127 with `cs`=1 reach the widest count in every stage of the chain.

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
  parameter int CMD_W      = 16,
  parameter int OP_W       = 8,
  parameter int DIV_W      = 7,
  parameter int PRE_DIV    = 29,
  parameter int EXT_DIV    = 8,
  parameter logic [OP_W-1:0]  OPCODE     = 8'hC8,
  parameter logic [CMD_W-1:0] RESET_WORD = 16'hC813
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  output logic             tick
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int EXT_W = $clog2(EXT_DIV);

  logic [DIV_W-1:0] div_r, div_cnt;
  logic             sel_r;
  logic [PRE_W-1:0] pre_cnt;
  logic [EXT_W-1:0] ext_cnt;
  logic             accept, pre_last, ext_last, div_last;

  assign accept   = wr_en && (wr_data[CMD_W-1 -: OP_W] == OPCODE);
  assign pre_last = (pre_cnt == PRE_W'(PRE_DIV - 1));
  assign ext_last = !sel_r || (ext_cnt == EXT_W'(EXT_DIV - 1));
  assign div_last = (div_cnt == div_r);
  assign tick     = pre_last && ext_last && div_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_r <= RESET_WORD[DIV_W-1:0];
      sel_r <= RESET_WORD[DIV_W];
    end else if (accept) begin
      div_r <= wr_data[DIV_W-1:0];
      sel_r <= wr_data[DIV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || accept) begin
      pre_cnt <= '0;
      ext_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
      if (pre_last)
        ext_cnt <= ext_last ? '0 : ext_cnt + 1'b1;
      if (pre_last && ext_last)
        div_cnt <= div_last ? '0 : div_cnt + 1'b1;
    end
  end

  // R1: an accepted word lands in the rate fields
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> (div_r == $past(wr_data[DIV_W-1:0])) && (sel_r == $past(wr_data[DIV_W])));

  // R2: other words leave rate and phase alone
  p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    (!accept && !$past(rst)) |=> $stable(div_r) && $stable(sel_r));

  // R5: strobe never lasts two cycles
  p_single_tick_r5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R6: power-on rate after reset
  p_reset_value_r6: assert property (@(posedge clk)
    rst |=> (div_r == RESET_WORD[DIV_W-1:0]) && (sel_r == RESET_WORD[DIV_W]) && !tick);

  // R7: accepted command restarts the chain
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> (pre_cnt == '0) && (ext_cnt == '0) && (div_cnt == '0));

  // R3: prescaler stays in range
  p_pre_range_r3: assert property (@(posedge clk) disable iff (rst)
    pre_cnt < PRE_W'(PRE_DIV));

  // R4: extra stage idle when not selected
  p_ext_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !sel_r |-> ext_cnt == '0);
endmodule

// File: tb/rate_tick_gen_tb.sv
module rate_tick_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  rate_tick_gen u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick(tick));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int period_of(int r, int cs);
    return 29 * (cs ? 8 : 1) * (r + 1);
  endfunction

  task automatic schedule(int start, int r, int cs, int n, string tag);
    int p;
    p = period_of(r, cs);
    exp_q.delete();
    tag_q.delete();
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(start + p - 1 + i * p);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic write_cmd(logic [15:0] w, bit en, bit accepted, int n, string tag);
    @(negedge clk);
    wr_en = en;
    wr_data = w;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (accepted) schedule(cyc, int'(w[6:0]), int'(w[7]), n, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!done) begin
      if (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s missing tick: actual none at %0d expected %0d", tag_q[0], cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (tick) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end else begin
          errors++;
          $display("FAIL R5 unexpected tick: actual %0d expected %0d", cyc,
                   exp_q.size() > 0 ? exp_q[0] : -1);
        end
      end
    end
  end

  initial begin
    // R6: tick low in reset
    repeat (3) @(negedge clk);
    checks++;
    if (tick !== 1'b0) begin errors++; $display("FAIL R6 tick in reset: actual %b expected 0", tick); end
    @(posedge clk); #1;
    rst = 1'b0;
    schedule(cyc, 19, 0, 2, "R6");
    drain();

    write_cmd(16'hC800, 1'b1, 1'b1, 3, "R8");   // R=0 cs=0
    drain();
    write_cmd(16'hC880, 1'b1, 1'b1, 3, "R8");   // R=0 cs=1
    drain();
    write_cmd(16'hC804, 1'b1, 1'b1, 3, "R3");   // period 145
    drain();
    write_cmd(16'hC885, 1'b1, 1'b1, 2, "R4");   // period 1392
    drain();
    write_cmd(16'hC802, 1'b1, 1'b1, 4, "R8");   // about 115.2 kbps
    drain();

    // R2: rejected words mid-period keep the phase
    write_cmd(16'hC80A, 1'b1, 1'b1, 3, "R2");   // period 319
    repeat (100) @(negedge clk);
    write_cmd(16'hC900, 1'b1, 1'b0, 0, "R2");
    repeat (50) @(negedge clk);
    write_cmd(16'h4880, 1'b1, 1'b0, 0, "R2");
    repeat (50) @(negedge clk);
    write_cmd(16'hC800, 1'b0, 1'b0, 0, "R2");
    drain();

    // R7: accepted write mid-period restarts
    write_cmd(16'hC810, 1'b1, 1'b1, 2, "R7");
    repeat (300) @(negedge clk);
    write_cmd(16'hC801, 1'b1, 1'b1, 3, "R7");
    drain();

    // R1: select bit and value both taken
    write_cmd(16'hC8FF, 1'b1, 1'b1, 1, "R1");   // R=127 cs=1
    drain();
    write_cmd(16'hC87F, 1'b1, 1'b1, 2, "R8");   // R=127 cs=0
    drain();
    write_cmd(16'hC8C7, 1'b1, 1'b1, 1, "R8");   // about 600 bps
    drain();

    // R6: reset mid-run reloads power-on rate
    write_cmd(16'hC803, 1'b1, 1'b1, 2, "R6");
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    schedule(cyc, 19, 0, 2, "R6");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule